// File: doc/BRIEF.md
# Toggle Bit Completion Poller

This block sits on the host side of a parallel flash device. Once a program or erase command has been written by other logic, it waits for the device's internal operation to finish. It reads the device over a simple request/ready memory bus and checks whether status bit 6 changes between two back-to-back reads. A changing bit 6 means the device is still busy. A steady bit 6 means the operation has finished.

Status bit 5 signals that the device has exceeded its internal time limit. The block does not act on that bit alone. Bit 6 can stop changing at the same moment that bit 5 goes high, so the block first reads one more pair and judges by that pair. If the device is still busy after that pair, the block writes a reset command so that the device returns to array reads, and then reports failure. An optional limit on the number of busy pairs gives a failure bound for a device that never sets bit 5.

A one-cycle `start` pulse begins a poll. The `done`, `pass` and `fail` outputs keep their values until the next `start`.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset, `bus_req`, `done`, `pass` and `fail` are all low.
- R2: Every read uses address `POLL_ADDR` with `bus_we` low. While `bus_req` is high and `bus_ready` is low, the request, `bus_we` and `bus_addr` do not change.
- R3: A pair of reads whose bit 6 values are equal ends the poll with `pass`. This holds whatever bit 5 shows. No further bus transfer follows, and `bus_req` stays low while `done` is high.
- R4: A pair whose bit 6 values differ, and whose second read shows bit 5 low, starts another pair. Bit 5 of the first read of a pair has no effect.
- R5: A pair whose bit 6 values differ, and whose second read shows bit 5 high, starts exactly one recheck pair. If bit 6 is steady in the recheck pair, the poll ends with `pass`.
- R6: If bit 6 still changes in the recheck pair, the block makes one write to `POLL_ADDR` with `bus_we` high and data 0xF0 in the low byte. It then ends with `fail`.
- R7: When `MAX_PAIRS` is nonzero, the `MAX_PAIRS`-th changing pair whose second read shows bit 5 low leads to the reset write and then `fail`. A changing pair whose second read shows bit 5 high still takes the recheck path. A value of 0 means there is no limit.
- R8: `done` and the result rise at the same clock edge that completes the poll's final bus transfer. Exactly one of `pass` and `fail` is high while `done` is high.
- R9: `done`, `pass` and `fail` hold until `start`. A `start` pulse clears them at the next edge, and `bus_req` rises at that same edge.
- R10: A `start` pulse during a poll is ignored. It does not change the transfers made or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a poll |
| bus_req | output | 1 | Transfer request, held until `bus_ready` |
| bus_we | output | 1 | 1 = write transfer, 0 = read transfer |
| bus_addr | output | AW | Transfer address |
| bus_wdata | output | DW | Write data (reset command) |
| bus_rdata | input | DW | Read data, valid with `bus_ready` |
| bus_ready | input | 1 | Transfer completes on an edge where `bus_req` and `bus_ready` are both high |
| done | output | 1 | Poll finished |
| pass | output | 1 | Operation completed |
| fail | output | 1 | Operation failed, reset command issued |

## Verification
`bus_req` rises at the edge that registers `start`. The bench's bus responder raises `bus_ready` after a chosen number of wait cycles. Each transfer completes at the edge where `bus_ready` is high, and the next request follows with no idle cycle. The final transfer and `done` share one edge, so the monitor requires `done` at the same falling-edge sample at which it logs the last completion. It also requires `done` to be low and `bus_req` to be high at the first falling edge after `start`. All checks sample on falling edges, and responder latencies of 0 to 3 cycles move these edges.

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl #(
  parameter int AW = 23,
  parameter int DW = 16,
  parameter logic [AW-1:0] POLL_ADDR = '0,
  parameter int MAX_PAIRS = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  output logic          done,
  output logic          pass,
  output logic          fail
);

  localparam int CW = (MAX_PAIRS < 2) ? 1 : $clog2(MAX_PAIRS + 1);
  localparam logic [DW-1:0] RST_CMD = DW'(8'hF0);

  typedef enum logic [2:0] {S_IDLE, S_RD1, S_RD2, S_WR, S_DONE} st_t;

  st_t st;
  logic first6, recheck, limit_hit;
  logic [CW-1:0] pairs;

  wire toggled = bus_rdata[6] ^ first6;
  wire dq5     = bus_rdata[5];
  wire can_go  = (st == S_IDLE) || (st == S_DONE);

  assign bus_req   = (st == S_RD1) || (st == S_RD2) || (st == S_WR);
  assign bus_we    = (st == S_WR);
  assign bus_addr  = POLL_ADDR;
  assign bus_wdata = bus_we ? RST_CMD : '0;

  generate
    if (MAX_PAIRS > 0) begin : g_limit
      assign limit_hit = (pairs == CW'(MAX_PAIRS - 1));
    end else begin : g_nolimit
      assign limit_hit = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      first6  <= 1'b0;
      recheck <= 1'b0;
      pairs   <= '0;
      done    <= 1'b0;
      pass    <= 1'b0;
      fail    <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE: begin
          if (start && can_go) begin
            st      <= S_RD1;
            recheck <= 1'b0;
            pairs   <= '0;
            done    <= 1'b0;
            pass    <= 1'b0;
            fail    <= 1'b0;
          end
        end
        S_RD1: begin
          if (bus_ready) begin
            first6 <= bus_rdata[6];
            st     <= S_RD2;
          end
        end
        S_RD2: begin
          if (bus_ready) begin
            if (!toggled) begin
              st   <= S_DONE;
              done <= 1'b1;
              pass <= 1'b1;
            end else if (recheck) begin
              st <= S_WR;
            end else if (dq5) begin
              recheck <= 1'b1;
              st      <= S_RD1;
            end else if (limit_hit) begin
              st <= S_WR;
            end else begin
              pairs <= pairs + 1'b1;
              st    <= S_RD1;
            end
          end
        end
        S_WR: begin
          if (bus_ready) begin
            st   <= S_DONE;
            done <= 1'b1;
            fail <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module toggle_poll_ctrl_chk #(
  parameter int AW = 23,
  parameter int DW = 16,
  parameter logic [AW-1:0] POLL_ADDR = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ready,
  input logic          done,
  input logic          pass,
  input logic          fail
);

  a_r2_poll_addr: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_addr == POLL_ADDR);

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ready |=> bus_req && $stable(bus_we) && $stable(bus_addr));

  a_r3_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);

  a_r6_reset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we |-> bus_wdata[7:0] == 8'hF0);

  a_r6_fail_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(bus_req && bus_we && bus_ready));

  a_r8_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass ^ fail));

  a_r8_no_result_early: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !pass && !fail);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(pass) && $stable(fail));

endmodule

bind toggle_poll_ctrl toggle_poll_ctrl_chk #(.AW(AW), .DW(DW), .POLL_ADDR(POLL_ADDR)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
  .done(done), .pass(pass), .fail(fail));

// File: tb/test_toggle_poll_ctrl.sv
module test_toggle_poll_ctrl;
  localparam int AW = 23;
  localparam int DW = 16;
  localparam logic [AW-1:0] ADDR = 23'h12345;
  localparam int MAXP = 4;

  logic clk = 0, rst_n = 0, start = 0;
  logic bus_req, bus_we, bus_ready = 0, done, pass, fail;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata = '0;

  always #2.5 clk = ~clk;

  toggle_poll_ctrl #(.AW(AW), .DW(DW), .POLL_ADDR(ADDR), .MAX_PAIRS(MAXP)) i_toggle_poll_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .done(done), .pass(pass), .fail(fail));

  typedef struct { string tag; int r; int w; bit p; } exp_t;
  exp_t exq[$];
  logic [DW-1:0] script[$];
  int n_chk = 0, n_fail = 0;
  int lat_cfg = 0, wcnt = 0, n_rd = 0, n_wr = 0;
  bit active = 0, comp;
  logic p_we;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_data;

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic add(bit d6, bit d5);
    logic [DW-1:0] v;
    v = DW'((script.size() + 3) * 16'h2B9);
    v[6] = d6;
    v[5] = d5;
    script.push_back(v);
  endtask

  // responder and scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      comp = 0;
      if (start && !active) begin
        active = 1; n_rd = 0; n_wr = 0; wcnt = 0;
      end
      if (bus_ready) begin
        bus_ready = 0;
        comp = 1;
        check(p_addr == ADDR, "R2", "transfer address", int'(p_addr), int'(ADDR));
        if (p_we) begin
          n_wr++;
          check(p_data[7:0] == 8'hF0, "R6", "reset command data", int'(p_data[7:0]), 'hF0);
        end else n_rd++;
      end
      if (bus_req) begin
        if (wcnt >= lat_cfg) begin
          bus_ready = 1;
          wcnt = 0;
          p_we = bus_we; p_addr = bus_addr; p_data = bus_wdata;
          if (!bus_we) bus_rdata = (script.size() > 0) ? script.pop_front() : '0;
        end else wcnt++;
      end
      if (active && done) begin
        exp_t e;
        active = 0;
        e = exq.pop_front();
        check(comp, e.tag, "done with final transfer edge (R8)", int'(comp), 1);
        check(n_rd == e.r, e.tag, "read count", n_rd, e.r);
        check(n_wr == e.w, e.tag, "write count", n_wr, e.w);
        check(pass == e.p && fail == !e.p, e.tag, "pass result", int'(pass), int'(e.p));
      end
    end
  end

  task automatic run(string tag, int lat, int r, int w, bit p, bit kick);
    exp_t e;
    bit ps;
    e.tag = tag; e.r = r; e.w = w; e.p = p;
    exq.push_back(e);
    lat_cfg = lat;
    @(negedge clk); #1 start = 1;
    @(negedge clk);
    check(!done && bus_req, "R9", "start clears done and requests", int'({done, bus_req}), 1);
    #1 start = 0;
    if (kick) begin
      repeat (4) @(negedge clk);
      #1 start = 1;
      @(negedge clk); #1 start = 0;
    end
    @(negedge clk);
    while (active) @(negedge clk);
    ps = pass;
    repeat (10) @(negedge clk);
    check(done && pass == ps && fail == !ps && !bus_req, "R9", "result held", int'({done, pass}), int'({1'b1, ps}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!bus_req && !done && !pass && !fail, "R1", "reset outputs", int'({bus_req, done, pass, fail}), 0);
    #1 rst_n = 1;
    @(negedge clk);
    check(!bus_req && !done, "R1", "idle after reset", int'({bus_req, done}), 0);

    add(0, 0); add(0, 0);
    run("R3", 0, 2, 0, 1, 0);
    add(1, 1); add(1, 1);
    run("R3", 1, 2, 0, 1, 0);
    add(0, 0); add(1, 0); add(0, 0); add(1, 0); add(1, 0); add(1, 0);
    run("R4", 1, 6, 0, 1, 0);
    add(1, 0); add(0, 1); add(1, 1); add(1, 1);
    run("R5", 0, 4, 0, 1, 0);
    add(0, 0); add(1, 1); add(0, 1); add(1, 1);
    run("R6", 2, 4, 1, 0, 0);
    for (int i = 0; i < 4; i++) begin add(0, 0); add(1, 0); end
    run("R7", 0, 8, 1, 0, 0);
    for (int i = 0; i < 4; i++) begin add(0, 1); add(1, 0); end
    run("R4", 1, 8, 1, 0, 0);
    for (int i = 0; i < 3; i++) begin add(0, 0); add(1, 0); end
    add(0, 0); add(1, 1); add(1, 0); add(1, 0);
    run("R7", 0, 10, 0, 1, 0);
    add(0, 0); add(1, 0); add(0, 0); add(1, 0); add(0, 0); add(0, 0);
    run("R10", 3, 6, 0, 1, 1);
    add(1, 0); add(0, 1); add(1, 0); add(0, 0);
    run("R6", 3, 4, 1, 0, 0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule